// File: doc/BRIEF.md
# Bit-Field Extract Unit with Condition Flags

This unit lifts a contiguous run of bits out of a 16-bit source word and returns it right-aligned and zero-extended. A processor datapath would use it as one of its ALU functions. One control byte carries the field description. Its upper nibble is the width code `w`, which selects a field of `w+1` bits. Its lower nibble is the start position `o`. If the field would extend past the top bit of the word, it is cut off at bit 15. It does not wrap around to bit 0.

An operation starts when `op_valid` is high on a rising clock edge. The unit registers the result and four condition flags, and raises `res_valid` for that one cycle. N copies the result's top bit. Z reports an all-zero result. V is always cleared. C is loaded from the incoming carry without change. When no operation is presented, the result and the flags keep their last values.

Top module: `bfx_unit`

## Requirements
- R1: The width code `w` is taken from `op_ctrl[7:4]` and the start position `o` from `op_ctrl[3:0]`.
- R2: The result holds source bits `[o+w:o]` at result bits `[w:0]`.
- R3: Every result bit above the extracted field is zero.
- R4: When `o+w > 15`, only source bits `[15:o]` are taken, so the field length is `16-o` and no low source bits appear above it.
- R5: `flag_n` equals bit 15 of the registered result.
- R6: `flag_z` is 1 exactly when the registered 16-bit result is zero.
- R7: `flag_v` is 0 after every operation.
- R8: `flag_c` takes the value of `carry_in` sampled with the operation.
- R9: The result and flags appear one clock after `op_valid`, and `res_valid` is high for exactly that cycle.
- R10: Without `op_valid`, the result and all flags hold their values, whatever `carry_in`, `op_src` and `op_ctrl` do.
- R11: An active-low asynchronous reset clears the result, all flags and `res_valid`.
- R12: `w=15` with `o=0` passes the whole source word through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_src | input | 16 | Source word |
| op_ctrl | input | 8 | Width code in [7:4], start position in [3:0] |
| carry_in | input | 1 | Incoming carry flag |
| res_valid | output | 1 | Result valid, one clock after `op_valid` |
| res_data | output | 16 | Extracted, right-aligned field |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always cleared |
| flag_c | output | 1 | Carry flag, passed through |

## Verification
The bench builds the unit with its default 16-bit word. With that word width the control byte has only 256 values, so the bench can cover every width and offset pair. It sweeps all 256 control values over all-zero, all-one, lone-top-bit, alternating and pseudo-random source words. The independent reference masks the shifted source to min(w+1, 16-o) bits, which covers every clipped field and the whole-word pass-through.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned POS_W  = $clog2(WORD_W);

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } bfx_flags_t;
endpackage

// File: rtl/bfx_field_mask.sv
module bfx_field_mask #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CW    = $clog2(DATA_W)
) (
  input  logic [CW-1:0]     width_i,
  output logic [DATA_W-1:0] mask_o
);
  // Bit g is kept when it lies inside the w+1 low positions.
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask_o[g] = (width_i >= CW'(g));
  end
endmodule

// File: rtl/bfx_align.sv
module bfx_align #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CW    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [CW-1:0]     off_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] field_o
);
  logic [DATA_W-1:0] shifted;

  // The logical shift fills with zeros from the top, so a field running past
  // the top bit is clipped there and never wraps.
  assign shifted = src_i >> off_i;
  assign field_o = shifted & mask_i;
endmodule

// File: rtl/bfx_flag_gen.sv
module bfx_flag_gen
  import bfx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] field_i,
  input  logic              carry_i,
  output bfx_flags_t        flags_o
);
  always_comb begin
    flags_o.n = field_i[DATA_W-1];
    flags_o.z = (field_i == '0);
    flags_o.v = 1'b0;
    flags_o.c = carry_i;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  localparam int unsigned CW    = $clog2(DATA_W),
  localparam int unsigned CTL_W = 2 * CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] op_src,
  input  logic [CTL_W-1:0]  op_ctrl,
  input  logic              carry_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  logic [CW-1:0]     width_code;
  logic [CW-1:0]     start_pos;
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] field;
  bfx_flags_t        flags_new;

  logic [DATA_W-1:0] data_d, data_q;
  bfx_flags_t        flags_d, flags_q;
  logic              vld_d, vld_q;

  // The upper half of the control byte is the width code, the lower half the start position.
  assign width_code = op_ctrl[CTL_W-1:CW];
  assign start_pos  = op_ctrl[CW-1:0];

  bfx_field_mask #(.DATA_W(DATA_W)) mask_i (
    .width_i (width_code),
    .mask_o  (keep_mask)
  );

  bfx_align #(.DATA_W(DATA_W)) align_i (
    .src_i   (op_src),
    .off_i   (start_pos),
    .mask_i  (keep_mask),
    .field_o (field)
  );

  bfx_flag_gen #(.DATA_W(DATA_W)) flags_i (
    .field_i (field),
    .carry_i (carry_in),
    .flags_o (flags_new)
  );

  // Next state: load only on an operation, otherwise keep the last values.
  always_comb begin
    vld_d   = op_valid;
    data_d  = data_q;
    flags_d = flags_q;
    if (op_valid) begin
      data_d  = field;
      flags_d = flags_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      vld_q   <= vld_d;
      data_q  <= data_d;
      flags_q <= flags_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = data_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_v    = flags_q.v;
  assign flag_c    = flags_q.c;

  AST_N_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_n == res_data[DATA_W-1])); // R5
  AST_Z_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_z == (res_data == '0))); // R6
  AST_V_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !flag_v); // R7
  AST_C_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flag_c == $past(carry_in))); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_data) && $stable(flag_c) && $stable(flag_z) && !res_valid)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((res_data >> ($past(width_code) + 1'b1)) == '0
                  || $past(width_code) == CW'(DATA_W-1))); // R3
endmodule

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [15:0] op_src;
  logic [7:0]  op_ctrl;
  logic        carry_in;
  logic        res_valid;
  logic [15:0] res_data;
  logic        flag_n, flag_z, flag_v, flag_c;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  bfx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_src(op_src),
    .op_ctrl(op_ctrl), .carry_in(carry_in), .res_valid(res_valid),
    .res_data(res_data), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  // Each entry: {source, control, expected result}
  localparam logic [39:0] VEC [10] = '{
    {16'hBEEF, 8'hF0, 16'hBEEF},   // R12 whole word
    {16'h00F0, 8'h34, 16'h000F},   // R2
    {16'h1234, 8'h7C, 16'h0001},   // R4 clipped
    {16'h8000, 8'h0F, 16'h0001},   // R1 one bit at top
    {16'hFFFF, 8'hFF, 16'h0001},   // R4 clipped to one bit
    {16'hA5C3, 8'h72, 16'h0070},   // R3
    {16'hFFFF, 8'hE1, 16'h7FFF},   // R4 exact fit
    {16'h0000, 8'hF0, 16'h0000},   // R6 zero
    {16'h5555, 8'h30, 16'h0005},   // R2
    {16'h8001, 8'hF0, 16'h8001}    // R5 negative
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_ext(input logic [15:0] s, input logic [7:0] c);
    int w = int'(c[7:4]);
    int o = int'(c[3:0]);
    int len = (w + 1 < 16 - o) ? w + 1 : 16 - o;
    int m = (1 << len) - 1;
    return 16'((int'(s) >> o) & m);
  endfunction

  // Drives one operation and checks the outputs on the following falling edge.
  task automatic run_op(input logic [15:0] s, input logic [7:0] c, input logic ci,
                        input logic [15:0] exp, input bit full);
    @(negedge clk);
    op_valid = 1'b1; op_src = s; op_ctrl = c; carry_in = ci;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R2/R3/R4 result", res_data, exp);
    if (full) begin
      chk("R9 valid", {15'd0, res_valid}, 16'd1);
      chk("R5 N", {15'd0, flag_n}, {15'd0, exp[15]});
      chk("R6 Z", {15'd0, flag_z}, {15'd0, exp == 16'd0});
      chk("R7 V", {15'd0, flag_v}, 16'd0);
      chk("R8 C", {15'd0, flag_c}, {15'd0, ci});
    end
  endtask

  initial begin
    logic [15:0] words [5];
    logic [15:0] lfsr;
    rst_n = 1'b0; op_valid = 1'b0; op_src = '0; op_ctrl = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 data", res_data, 16'd0);
    chk("R11 flags", {11'd0, res_valid, flag_n, flag_z, flag_v, flag_c}, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++)
      run_op(VEC[i][39:24], VEC[i][23:16], 1'(i % 2), VEC[i][15:0], 1'b1);

    // R9 valid falls after one cycle; R10 hold with other inputs toggling
    run_op(16'h8421, 8'hF0, 1'b1, 16'h8421, 1'b1);
    op_src = 16'h0000; op_ctrl = 8'h00; carry_in = 1'b0;
    @(negedge clk);
    chk("R9 valid drops", {15'd0, res_valid}, 16'd0);
    chk("R10 data hold", res_data, 16'h8421);
    chk("R10 C hold", {15'd0, flag_c}, 16'd1);
    chk("R10 N/Z hold", {14'd0, flag_n, flag_z}, 16'd2);

    // R1 R2 R3 R4 full control sweep against the reference
    words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'h8000;
    words[3] = 16'hAAAA; words[4] = 16'h5555;
    lfsr = 16'hACE1;
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 6; k++) begin
        logic [15:0] s;
        if (k < 5) s = words[k];
        else begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          s = lfsr;
        end
        run_op(s, 8'(c), 1'(k % 2), ref_ext(s, 8'(c)), (k == 5));
      end
    end

    // R11 reset in mid-run
    run_op(16'hFFFF, 8'hF0, 1'b1, 16'hFFFF, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R11 async data", res_data, 16'd0);
    chk("R11 async flags", {12'd0, flag_n, flag_z, flag_v, flag_c}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule